// File: doc/BRIEF.md
# Sticky Overload Alarm Status Unit

This block collects the overload alarms of a gain amplifier. There are four monitor points, two at the amplifier input and two at its output. Each point has a low-threshold comparator and a high-threshold comparator, which gives eight raw alarm lines in total. Every line passes through a two-flop synchronizer. Each alarm is then held in a sticky status bit that stays set after the condition goes away, so a transient lasting a single sampled cycle is still recorded.

A separate interface CRC error, which arrives as a one-cycle pulse, is held in its own sticky flag. A summary bit is formed as the OR of all eight held alarms and the held CRC flag. It drives an output pin and is also bit 4 of the main status byte, which software polls. Software then reads the alarm register and the CRC register to find the cause. Each of those two reads clears only its own flags, so the summary bit falls only once both registers have been read.

Reads use an address and a one-cycle read strobe. Read data is registered and appears in the cycle after the strobe. When a clearing read and a new event fall in the same cycle, the read returns the old contents and the new event stays held.

Top module: `overload_alarm_status`

## Requirements
- R1: Alarm input bit i maps to bit i of the alarm register at address 0x11. The order from bit 7 down to bit 0 is: output point 2 high, output point 2 low, output point 1 high, output point 1 low, input point 2 high, input point 2 low, input point 1 high, input point 1 low.
- R2: A held alarm bit stays set after its raw input returns low, until the alarm register is read.
- R3: A read of 0x11 returns the held alarms on `rdData` in the cycle after the strobe, and clears all eight bits.
- R4: `summaryOut` equals the OR of the eight held alarms and the held CRC flag. A read of 0x01 returns the same value at bit 4, with all other bits 0.
- R5: The summary falls only after both registers holding set flags have been read. Reading only one of them leaves it high.
- R6: A one-cycle `crcErrPulse` sets the CRC flag. A read of 0x12 returns it at bit 0, with all other bits 0, and clears it.
- R7: A raw alarm pulse lasting one clock cycle is captured. It becomes visible on `summaryOut` three rising edges after it is sampled.
- R8: If an alarm or CRC event is held in the same cycle as the read that clears its register, the read returns the prior value and the new event stays held.
- R9: A read of any address other than 0x01, 0x11 and 0x12 returns 0x00 and changes no flag.
- R10: Reset (`rstN` low) clears every held flag, the summary and `rdData`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| alarmRaw | input | 8 | Raw comparator outputs, asynchronous |
| crcErrPulse | input | 1 | One-cycle interface CRC error |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 8 | Read address |
| rdData | output | 8 | Registered read data, valid the cycle after `rdEn` |
| summaryOut | output | 1 | Polled summary of all held errors |

## Verification
The hardest case to reach is the collision of R8. A synchronized alarm must land on exactly the same clock edge as the clearing read of 0x11. From the ports, this means starting the raw pulse two cycles before the read strobe, so that it clears the synchronizer on the read edge. The bench builds this by driving the pulse and then issuing the read after a fixed count of falling edges. It expects the first read to return only the older alarm and a second read to return only the new one. The CRC collision is simpler: the pulse and the 0x12 read strobe are driven in the same cycle.

// File: rtl/overload_alarm_pkg.sv
package overload_alarm_pkg;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 8;
  localparam int NUM_POINTS  = 4;
  localparam int NUM_ALARMS  = NUM_POINTS * 2;
  localparam int SYNC_STAGES = 2;
  localparam int SUMMARY_BIT = 4;
  localparam int CRC_BIT     = 0;

  localparam logic [ADDR_W-1:0] MAIN_ADDR  = 8'h01;
  localparam logic [ADDR_W-1:0] ALARM_ADDR = 8'h11;
  localparam logic [ADDR_W-1:0] CRC_ADDR   = 8'h12;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_MAIN  = 2'd1,
    SEL_ALARM = 2'd2,
    SEL_CRC   = 2'd3
  } readSel_e;

  typedef struct packed {
    logic     clrAlarm;
    logic     clrCrc;
    readSel_e sel;
  } strobe_t;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stage[0] <= '0;
    else       stage[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stage[s] <= '0;
      else       stage[s] <= stage[s-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/status_ctrl.sv
module status_ctrl
  import overload_alarm_pkg::*;
(
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           strb
);
  always_comb begin
    strb = '{clrAlarm: 1'b0, clrCrc: 1'b0, sel: SEL_NONE};
    if (rdEn) begin
      unique case (rdAddr)
        MAIN_ADDR:  strb.sel = SEL_MAIN;
        ALARM_ADDR: begin
          strb.sel      = SEL_ALARM;
          strb.clrAlarm = 1'b1;
        end
        CRC_ADDR: begin
          strb.sel    = SEL_CRC;
          strb.clrCrc = 1'b1;
        end
        default:    strb.sel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/status_datapath.sv
module status_datapath
  import overload_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ALARMS-1:0] syncedAlarm,
  input  logic                  crcErrPulse,
  input  strobe_t               strb,
  output logic [NUM_ALARMS-1:0] alarmLat,
  output logic                  crcLat,
  output logic                  summary,
  output logic [DATA_W-1:0]     rdData
);
  logic [NUM_ALARMS-1:0] alarmNext;
  logic                  crcNext;
  logic [DATA_W-1:0]     rdNext;

  // Clear first, then OR in the new events, so a colliding event survives.
  always_comb begin
    alarmNext = (strb.clrAlarm ? '0 : alarmLat) | syncedAlarm;
    crcNext   = (strb.clrCrc ? 1'b0 : crcLat) | crcErrPulse;
  end

  assign summary = (|alarmLat) | crcLat;

  always_comb begin
    rdNext = '0;
    unique case (strb.sel)
      SEL_MAIN:  rdNext[SUMMARY_BIT] = summary;
      SEL_ALARM: rdNext[NUM_ALARMS-1:0] = alarmLat;
      SEL_CRC:   rdNext[CRC_BIT] = crcLat;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alarmLat <= '0;
      crcLat   <= 1'b0;
      rdData   <= '0;
    end else begin
      alarmLat <= alarmNext;
      crcLat   <= crcNext;
      rdData   <= rdNext;
    end
  end
endmodule

// File: rtl/overload_alarm_status.sv
module overload_alarm_status
  import overload_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_ALARMS-1:0] alarmRaw,
  input  logic                  crcErrPulse,
  input  logic                  rdEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  output logic                  summaryOut
);
  logic [NUM_ALARMS-1:0] syncedAlarm;
  logic [NUM_ALARMS-1:0] alarmLat;
  logic                  crcLat;
  strobe_t               strb;

  alarm_sync #(.WIDTH(NUM_ALARMS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(alarmRaw), .dout(syncedAlarm)
  );

  status_ctrl u_ctrl (
    .rdEn(rdEn), .rdAddr(rdAddr), .strb(strb)
  );

  status_datapath u_dp (
    .clk(clk), .rstN(rstN), .syncedAlarm(syncedAlarm),
    .crcErrPulse(crcErrPulse), .strb(strb), .alarmLat(alarmLat),
    .crcLat(crcLat), .summary(summaryOut), .rdData(rdData)
  );
endmodule

// File: rtl/overload_alarm_checker.sv
module overload_alarm_checker
  import overload_alarm_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  rdEn,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic [DATA_W-1:0]     rdData,
  input logic [NUM_ALARMS-1:0] alarmLat,
  input logic [NUM_ALARMS-1:0] syncedAlarm,
  input logic                  crcLat,
  input logic                  crcErrPulse,
  input logic                  summaryOut
);
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(rdEn && rdAddr == ALARM_ADDR) |=> ((alarmLat & $past(alarmLat)) == $past(alarmLat))); // R2

  AST_READ_OLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ALARM_ADDR) |=> (rdData == $past(alarmLat))); // R3

  AST_SUMMARY_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(summaryOut) |-> $past(rdEn && (rdAddr == ALARM_ADDR || rdAddr == CRC_ADDR))); // R5

  AST_CRC_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    crcErrPulse |=> crcLat); // R6

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (syncedAlarm != '0) |=> ((alarmLat & $past(syncedAlarm)) == $past(syncedAlarm))); // R8

  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr != MAIN_ADDR && rdAddr != ALARM_ADDR && rdAddr != CRC_ADDR)
      |=> (rdData == '0)); // R9

  AST_SUMMARY_PIN: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == MAIN_ADDR) |=> (rdData[SUMMARY_BIT] == $past(summaryOut))); // R4
endmodule

bind overload_alarm_status overload_alarm_checker u_chk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData),
  .alarmLat(alarmLat), .syncedAlarm(syncedAlarm), .crcLat(crcLat),
  .crcErrPulse(crcErrPulse), .summaryOut(summaryOut)
);

// File: tb/tb_overload_alarm_status.sv
`timescale 1ns/1ps
module tb_overload_alarm_status;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] alarmRaw = '0;
  logic       crcErrPulse = 1'b0;
  logic       rdEn = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;
  logic       summaryOut;

  int tests = 0;
  int fails = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdEnD = 1'b0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  overload_alarm_status dut (
    .clk(clk), .rstN(rstN), .alarmRaw(alarmRaw), .crcErrPulse(crcErrPulse),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .summaryOut(summaryOut)
  );

  always @(posedge clk) rdEnD <= rdEn;

  // Monitor: pops the expected read result in the cycle after each strobe.
  always @(negedge clk) begin
    if (rdEnD) begin
      tests++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data actual=%02h expected=none", rdData);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        if (rdData !== e) begin
          fails++;
          $display("FAIL %s read actual=%02h expected=%02h", t, rdData, e);
        end
      end
    end
  end

  task automatic doRead(input logic [7:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(t);
    rdEn = 1'b1;
    rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    rdAddr = '0;
  endtask

  task automatic checkSum(input logic e, input string t);
    tests++;
    if (summaryOut !== e) begin
      fails++;
      $display("FAIL %s summary actual=%0b expected=%0b", t, summaryOut, e);
    end
  endtask

  task automatic pulseAlarm(input logic [7:0] m);
    @(negedge clk);
    alarmRaw = m;
    @(negedge clk);
    alarmRaw = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseCrc();
    @(negedge clk);
    crcErrPulse = 1'b1;
    @(negedge clk);
    crcErrPulse = 1'b0;
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    checkSum(1'b0, "R10");
    doRead(8'h11, 8'h00, "R10");
    doRead(8'h12, 8'h00, "R10");
    doRead(8'h01, 8'h00, "R10");

    // R7 R1 R4: single-cycle pulse on input point 1 low
    pulseAlarm(8'h01);
    checkSum(1'b1, "R7");
    doRead(8'h01, 8'h10, "R4");
    doRead(8'h11, 8'h01, "R1");
    doRead(8'h11, 8'h00, "R3");
    checkSum(1'b0, "R3");

    // R7 latency: two edges after sampling still clear, third sets
    @(negedge clk);
    alarmRaw = 8'h80;
    @(negedge clk);
    alarmRaw = '0;
    @(negedge clk);
    checkSum(1'b0, "R7");
    @(negedge clk);
    checkSum(1'b1, "R7");
    doRead(8'h11, 8'h80, "R1");

    // R2: held pattern, then released before reading
    @(negedge clk);
    alarmRaw = 8'hA5;
    repeat (5) @(negedge clk);
    alarmRaw = '0;
    repeat (6) @(negedge clk);
    checkSum(1'b1, "R2");
    doRead(8'h11, 8'hA5, "R2");
    doRead(8'h11, 8'h00, "R3");

    // R6: CRC flag
    pulseCrc();
    @(negedge clk);
    checkSum(1'b1, "R6");
    doRead(8'h01, 8'h10, "R4");
    doRead(8'h12, 8'h01, "R6");
    checkSum(1'b0, "R6");
    doRead(8'h12, 8'h00, "R6");

    // R5: both sources, alarm register read first
    pulseAlarm(8'h40);
    pulseCrc();
    doRead(8'h11, 8'h40, "R5");
    @(negedge clk);
    checkSum(1'b1, "R5");
    doRead(8'h12, 8'h01, "R5");
    checkSum(1'b0, "R5");

    // R5: reverse order
    pulseCrc();
    pulseAlarm(8'h02);
    doRead(8'h12, 8'h01, "R5");
    checkSum(1'b1, "R5");
    doRead(8'h01, 8'h10, "R5");
    doRead(8'h11, 8'h02, "R5");
    checkSum(1'b0, "R5");

    // R9: other addresses
    pulseAlarm(8'h20);
    pulseCrc();
    doRead(8'h05, 8'h00, "R9");
    doRead(8'hFF, 8'h00, "R9");
    doRead(8'h00, 8'h00, "R9");
    checkSum(1'b1, "R9");
    doRead(8'h11, 8'h20, "R9");
    doRead(8'h12, 8'h01, "R9");

    // R8: alarm collision with clearing read
    pulseAlarm(8'h01);
    @(negedge clk);
    alarmRaw = 8'h80;
    @(negedge clk);
    alarmRaw = '0;
    @(negedge clk);
    expQ.push_back(8'h01);
    tagQ.push_back("R8");
    rdEn = 1'b1;
    rdAddr = 8'h11;
    @(negedge clk);
    rdEn = 1'b0;
    rdAddr = '0;
    checkSum(1'b1, "R8");
    doRead(8'h11, 8'h80, "R8");

    // R8: CRC pulse in the same cycle as the 0x12 read
    @(negedge clk);
    crcErrPulse = 1'b1;
    expQ.push_back(8'h00);
    tagQ.push_back("R8");
    rdEn = 1'b1;
    rdAddr = 8'h12;
    @(negedge clk);
    crcErrPulse = 1'b0;
    rdEn = 1'b0;
    rdAddr = '0;
    checkSum(1'b1, "R8");
    doRead(8'h12, 8'h01, "R8");

    // R10: reset with flags set
    pulseAlarm(8'hFF);
    pulseCrc();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkSum(1'b0, "R10");
    doRead(8'h11, 8'h00, "R10");
    doRead(8'h12, 8'h00, "R10");

    repeat (3) @(negedge clk);
    tests++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    done = 1'b1;
    finishRun();
  end
endmodule